// File: doc/BRIEF.md
# NAND Flash Read-Path Command Decoder

This block is the device-facing front end of a small-page NAND flash read path. It watches the flash control strobes and the 8-bit data bus on a system clock. Falling edges of the write strobe carry command and address bytes in. Falling edges of the read strobe carry data bytes out. Two chip enables select one of two independent devices. Each device keeps its own read mode, byte address, address-cycle counter and sticky error flag.

The byte address is linear. Pages are 528 bytes long. The first address byte sets the column and gets an offset that depends on the read mode. The second address byte selects a group of 256 pages. The third selects a page within that group. The storage array sits outside the block, behind a synchronous byte-read port with one cycle of latency. Each read strobe issues one storage read and then advances the address by one.

Top module: `nand_rd_front`

## Requirements
- R1: After reset, `bus_oe` is 0, `bus_out` is 0, both `rdy` bits are 0 and both `err` bits are 0.
- R2: A command byte is taken when WE falls while CLE is high. The command codes are:
  - 0xFF: return to idle and clear the device's `err`.
  - 0x00: enter read mode 1.
  - 0x01: enter read mode 2.
  - 0x50: enter read mode 3.
  - Each of the three read commands resets the address-cycle counter.
- R3: An address byte is taken when WE falls while ALE is high and CLE is low. Address bytes build the address as follows:
  - Byte 1 sets the address to the byte value, ORed with 0x000 in mode 1, 0x100 in mode 2 or 0x200 in mode 3.
  - Byte 2 adds the byte value × 135168 (528 × 256).
  - Byte 3 adds the byte value × 528.
  - The sum wraps modulo 2^24.
- R4: A read is taken when RE falls while CLE and ALE are low.
  - In that cycle `mem_rd` is 1 and `mem_addr` holds the current address.
  - After the next clock edge `bus_oe` is 1 and `bus_out` shows the storage byte.
  - The address then goes up by one for the following read.
- R5: The devices are selected as follows:
  - `cs0_n` low selects device 0, whatever `cs1_n` is.
  - Otherwise `cs1_n` low selects device 1.
  - `mem_dev` gives the selected device on a read.
  - The two devices keep separate address state.
- R6: With both chip enables high, strobe edges have no effect: `mem_rd` stays 0, no device state changes, and `bus_oe` is 0 after the next edge.
- R7: While a device is selected with RE and WE both high, its `rdy` bit is 1 after the next edge and `bus_oe` is 0.
- R8: An unknown command byte sets the device's sticky `err` and puts the device in idle.
- R9: Two kinds of address byte set `err` and put the device in idle without changing its address:
  - an address byte received in idle;
  - a fourth address byte after a read command.
- R10: Each falling strobe edge starts at most one action. Holding WE or RE low for several cycles repeats nothing, and `mem_rd` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs0_n | input | 1 | Chip enable for device 0, active low, has priority |
| cs1_n | input | 1 | Chip enable for device 1, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| bus_in | input | 8 | Data bus input (commands and address bytes) |
| bus_out | output | 8 | Data bus output (read bytes) |
| bus_oe | output | 1 | Data bus output enable |
| rdy | output | 2 | Ready line per device |
| err | output | 2 | Sticky protocol error flag per device |
| mem_rd | output | 1 | Storage byte-read request |
| mem_dev | output | 1 | Device addressed by the storage read |
| mem_addr | output | 24 | Byte address for the storage read |
| mem_data | input | 8 | Storage read data, valid one cycle after `mem_rd` |

## Verification
The corner that is hardest to reach from the ports is the fourth address byte. It must be rejected without disturbing the address already built, and no status port shows the address. The stimulus loads three address bytes, sends a fourth, and then issues a read. The address shown on `mem_addr` proves the state survived.

Cross-device isolation is checked in a similar way. Reads are interleaved between the two chip enables, including a cycle with both enables low, and the separate read pointers must advance independently. A sweep over all three modes and corner byte values covers the page arithmetic, including wrap-around at 2^24.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_LO    = 2'd1,
        MODE_HI    = 2'd2,
        MODE_SPARE = 2'd3
    } rd_mode_e;

    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_LO    = 8'h00;
    localparam logic [7:0] CMD_HI    = 8'h01;
    localparam logic [7:0] CMD_SPARE = 8'h50;

    function automatic logic [9:0] mode_offset(rd_mode_e m);
        case (m)
            MODE_HI:    return 10'h100;
            MODE_SPARE: return 10'h200;
            default:    return 10'h000;
        endcase
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic re_n,
    input  logic we_n,
    output logic re_fall,
    output logic we_fall
);
    typedef struct packed {
        logic re;
        logic we;
    } edge_st_t;

    edge_st_t s_q, s_d;

    always_comb begin
        s_d.re = re_n;
        s_d.we = we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{re: 1'b1, we: 1'b1};
        else        s_q <= s_d;
    end

    assign re_fall = s_q.re & ~re_n;
    assign we_fall = s_q.we & ~we_n;
endmodule

// File: rtl/nand_dev_ctx.sv
module nand_dev_ctx
    import nand_rd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 528
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic              adr_stb,
    input  logic              rd_stb,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    localparam int GROUP_BYTES = PAGE_BYTES * 256;

    typedef struct packed {
        rd_mode_e          mode;
        logic [1:0]        cyc;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } ctx_t;

    ctx_t c_q, c_d;
    logic [ADDR_W-1:0] grp_step, page_step;

    always_comb begin
        grp_step  = ADDR_W'(din) * ADDR_W'(GROUP_BYTES);
        page_step = ADDR_W'(din) * ADDR_W'(PAGE_BYTES);
        c_d = c_q;
        if (cmd_stb) begin
            case (din)
                CMD_RESET: begin c_d.mode = MODE_IDLE;  c_d.err = 1'b0; end
                CMD_LO:    begin c_d.mode = MODE_LO;    c_d.cyc = 2'd0; end
                CMD_HI:    begin c_d.mode = MODE_HI;    c_d.cyc = 2'd0; end
                CMD_SPARE: begin c_d.mode = MODE_SPARE; c_d.cyc = 2'd0; end
                default:   begin c_d.mode = MODE_IDLE;  c_d.err = 1'b1; end
            endcase
        end else if (adr_stb) begin
            if (c_q.mode == MODE_IDLE || c_q.cyc == 2'd3) begin
                c_d.mode = MODE_IDLE;
                c_d.err  = 1'b1;
            end else begin
                case (c_q.cyc)
                    2'd0:    c_d.addr = ADDR_W'(din) | ADDR_W'(mode_offset(c_q.mode));
                    2'd1:    c_d.addr = c_q.addr + grp_step;
                    default: c_d.addr = c_q.addr + page_step;
                endcase
                c_d.cyc = c_q.cyc + 2'd1;
            end
        end else if (rd_stb) begin
            c_d.addr = c_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{mode: MODE_IDLE, cyc: 2'd0, addr: '0, err: 1'b0};
        else        c_q <= c_d;
    end

    assign addr = c_q.addr;
    assign err  = c_q.err;
endmodule

// File: rtl/nand_rd_front.sv
module nand_rd_front #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 528
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              re_n,
    input  logic              we_n,
    input  logic              cle,
    input  logic              ale,
    input  logic [7:0]        bus_in,
    output logic [7:0]        bus_out,
    output logic              bus_oe,
    output logic [1:0]        rdy,
    output logic [1:0]        err,
    output logic              mem_rd,
    output logic              mem_dev,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data
);
    localparam int NDEV = 2;

    typedef struct packed {
        logic            oe;
        logic [NDEV-1:0] rdy;
    } front_t;

    front_t f_q, f_d;
    logic re_fall, we_fall;
    logic any_sel, dev_idx;
    logic cmd_evt, adr_evt, rd_evt;
    logic [ADDR_W-1:0] dev_addr [NDEV];

    nand_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .re_n(re_n), .we_n(we_n),
        .re_fall(re_fall), .we_fall(we_fall)
    );

    assign any_sel = ~cs0_n | ~cs1_n;
    assign dev_idx = cs0_n;
    assign cmd_evt = any_sel & we_fall & cle;
    assign adr_evt = any_sel & we_fall & ale & ~cle;
    assign rd_evt  = any_sel & re_fall & ~cle & ~ale;

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        logic hit;
        assign hit = any_sel & (dev_idx == 1'(g));
        nand_dev_ctx #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctx (
            .clk(clk), .rst_n(rst_n),
            .cmd_stb(cmd_evt & hit), .adr_stb(adr_evt & hit),
            .rd_stb(rd_evt & hit), .din(bus_in),
            .addr(dev_addr[g]), .err(err[g])
        );
    end

    always_comb begin
        f_d = f_q;
        if (!any_sel) begin
            f_d.oe = 1'b0;
        end else if (re_n && we_n) begin
            f_d.oe           = 1'b0;
            f_d.rdy[dev_idx] = 1'b1;
        end else if (rd_evt) begin
            f_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{oe: 1'b0, rdy: '0};
        else        f_q <= f_d;
    end

    assign mem_rd   = rd_evt;
    assign mem_dev  = dev_idx;
    assign mem_addr = dev_addr[dev_idx];
    assign bus_oe   = f_q.oe;
    assign bus_out  = f_q.oe ? mem_data : 8'h00;
    assign rdy      = f_q.rdy;
endmodule

// File: rtl/nand_rd_front_chk.sv
module nand_rd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic       re_n,
    input logic       we_n,
    input logic       bus_oe,
    input logic [1:0] rdy,
    input logic       mem_rd,
    input logic       mem_dev
);
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cs0_n || !cs1_n) && re_n && we_n) |=> !bus_oe); // R7
    AST_RDY_DEV0: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs0_n && re_n && we_n) |=> rdy[0]); // R7
    AST_NOSEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |-> !mem_rd); // R6
    AST_NOSEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> !bus_oe); // R6
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> bus_oe); // R4
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R10
    AST_CS0_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !cs0_n) |-> !mem_dev); // R5
endmodule

bind nand_rd_front nand_rd_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .re_n(re_n), .we_n(we_n), .bus_oe(bus_oe), .rdy(rdy),
    .mem_rd(mem_rd), .mem_dev(mem_dev)
);

// File: tb/nand_rd_front_test.sv
module nand_rd_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs0_n = 1'b1, cs1_n = 1'b1, re_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic bus_oe, mem_rd, mem_dev;
    logic [1:0] rdy, err;
    logic [23:0] mem_addr;
    logic [7:0] mem_data = 8'h00;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    nand_rd_front uut (
        .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .re_n(re_n), .we_n(we_n), .cle(cle), .ale(ale), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rdy(rdy), .err(err),
        .mem_rd(mem_rd), .mem_dev(mem_dev), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [7:0] pat(logic d, logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ (d ? 8'h5A : 8'h00);
    endfunction

    always @(posedge clk) if (mem_rd) mem_data <= pat(mem_dev, mem_addr);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // sel: 0 dev0, 1 dev1, 2 none, 3 both low
    task automatic set_cs(int sel);
        cs0_n = !(sel == 0 || sel == 3);
        cs1_n = !(sel == 1 || sel == 3);
    endtask

    task automatic wr(int sel, bit c, bit a, logic [7:0] d, int hold = 1);
        @(negedge clk);
        set_cs(sel); cle = c; ale = a; bus_in = d; we_n = 1'b0;
        repeat (hold) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic load(int sel, logic [7:0] cmd, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2);
        wr(sel, 1, 0, cmd);
        wr(sel, 0, 1, a0);
        wr(sel, 0, 1, a1);
        wr(sel, 0, 1, a2);
    endtask

    task automatic rd(int sel, logic [23:0] ea, string req);
        logic d;
        d = (sel == 1);
        @(negedge clk);
        set_cs(sel); re_n = 1'b0;
        #1;
        chk(mem_rd === 1'b1, req, "mem_rd", mem_rd, 1);
        chk(mem_addr === ea, req, "mem_addr", mem_addr, ea);
        chk(mem_dev === d, req, "mem_dev", mem_dev, d);
        @(negedge clk);
        chk(bus_oe === 1'b1 && bus_out === pat(d, ea), req, "bus_out", {bus_oe, bus_out}, {1'b1, pat(d, ea)});
        re_n = 1'b1;
        @(negedge clk);
        chk(bus_oe === 1'b0, "R7", "bus release", bus_oe, 0);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] cmds [3];
        logic [7:0] vd0 [3];
        logic [7:0] vd1 [4];
        logic [7:0] vd2 [4];
        logic [23:0] a_base, b_base, e;
        int k;
        cmds = '{8'h00, 8'h01, 8'h50};
        vd0 = '{8'h00, 8'h3C, 8'hFF};
        vd1 = '{8'h00, 8'h01, 8'h80, 8'hFF};
        vd2 = '{8'h00, 8'h01, 8'h1F, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_oe === 1'b0, "R1", "bus_oe", bus_oe, 0);
        chk(bus_out === 8'h00, "R1", "bus_out", bus_out, 0);
        chk(rdy === 2'b00, "R1", "rdy", rdy, 0);
        chk(err === 2'b00, "R1", "err", err, 0);

        // R7 ready per selected device
        wr(0, 1, 0, 8'hFF);
        @(negedge clk);
        chk(rdy === 2'b01, "R7", "rdy dev0 only", rdy, 1);

        // R2 R3 sweep over modes and corner bytes; R4 sequential reads
        k = 0;
        for (int m = 0; m < 3; m++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 4; j++)
                    for (int l = 0; l < 4; l++) begin
                        e = 24'((longint'(vd0[i]) | (m * 256)) + longint'(vd1[j]) * 135168
                                + longint'(vd2[l]) * 528);
                        load(k % 2, cmds[m], vd0[i], vd1[j], vd2[l]);
                        rd(k % 2, e, "R3");
                        rd(k % 2, e + 24'd1, "R4");
                        k++;
                    end
        chk(rdy === 2'b11, "R7", "rdy both", rdy, 3);
        chk(err === 2'b00, "R2", "no error after valid use", err, 0);

        // R5 separate state and chip-enable priority
        a_base = 24'd5 + 24'd2 * 24'd135168 + 24'd3 * 24'd528;
        b_base = 24'h200 + 24'd7 + 24'd9 * 24'd528;
        load(0, 8'h00, 8'd5, 8'd2, 8'd3);
        load(1, 8'h50, 8'd7, 8'd0, 8'd9);
        rd(0, a_base, "R5");
        rd(1, b_base, "R5");
        rd(0, a_base + 24'd1, "R5");
        rd(3, a_base + 24'd2, "R5");

        // R6 no selection: strobes ignored
        @(negedge clk);
        set_cs(2); re_n = 1'b0;
        #1;
        chk(mem_rd === 1'b0, "R6", "mem_rd", mem_rd, 0);
        @(negedge clk);
        chk(bus_oe === 1'b0, "R6", "bus_oe", bus_oe, 0);
        re_n = 1'b1;
        wr(2, 0, 1, 8'h44);
        rd(0, a_base + 24'd3, "R6");
        chk(err === 2'b00, "R6", "err", err, 0);

        // R10 held WE counts once, held RE reads once
        wr(0, 1, 0, 8'h00);
        wr(0, 0, 1, 8'h10, 3);
        wr(0, 0, 1, 8'h00);
        wr(0, 0, 1, 8'h00);
        @(negedge clk);
        set_cs(0); re_n = 1'b0;
        @(negedge clk);
        #1;
        chk(mem_rd === 1'b0, "R10", "mem_rd held RE", mem_rd, 0);
        @(negedge clk);
        re_n = 1'b1;
        rd(0, 24'h11, "R10");
        chk(err[0] === 1'b0, "R10", "err", err[0], 0);

        // R9 fourth address byte
        load(0, 8'h00, 8'd5, 8'd0, 8'd2);
        wr(0, 0, 1, 8'h07);
        chk(err[0] === 1'b1, "R9", "err fourth byte", err[0], 1);
        rd(0, 24'd1061, "R9");

        // R2 reset command clears error
        wr(0, 1, 0, 8'hFF);
        chk(err[0] === 1'b0, "R2", "err cleared", err[0], 0);

        // R9 address byte in idle
        wr(0, 0, 1, 8'h33);
        chk(err[0] === 1'b1, "R9", "err idle address", err[0], 1);
        rd(0, 24'd1062, "R9");

        // R8 unknown command on device 1
        wr(1, 1, 0, 8'h33);
        chk(err === 2'b11, "R8", "err unknown cmd", err, 3);
        wr(1, 0, 1, 8'h01);
        chk(err[1] === 1'b1, "R8", "idle after unknown", err[1], 1);
        wr(1, 1, 0, 8'hFF);
        chk(err === 2'b01, "R2", "err dev1 cleared only", err, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule